// File: doc/BRIEF.md
# Serial Flash Page Program Engine

This block sits on the memory side of an SPI link and handles two commands: the one that arms writing and the one that programs a page. The SPI pins are sampled by the block's own clock. A write-enable byte sets an internal latch. A program frame then carries an opcode, a three-byte address and one or more data bytes. The data bytes land in a page buffer indexed by the low address byte. When the data runs past the last byte of the page, it wraps to the first byte of the same page.

When chip select rises cleanly after at least one whole data byte, the engine starts a program cycle. It holds `busy` for a fixed number of clocks. During that window it performs one read-modify-write on an external byte array for every buffered offset, in ascending order. Each write stores the old byte ANDed with the new byte, so bits can only go from 1 to 0. Commands that arrive while `busy` is high are ignored. The write-enable latch drops when the cycle finishes, and also when a program frame ends badly.

Top module: `spi_pp_engine`

## Requirements
- R1: After reset `busy` and `wel` are 0, and neither `mem_rd_en` nor `mem_wr_en` is asserted.
- R2: A frame whose first byte is 0x06 sets `wel`. A program frame is accepted only while `wel` is 1.
- R3: A frame starting with 0x02 while `wel` is 0 causes no program cycle and no array write, and `wel` stays 0.
- R4: Bits are sampled MSB first on rising `spi_sclk` while `spi_cs_n` is low. A program frame is 0x02, then address bytes A[23:16], A[15:8], A[7:0], then the data bytes. Data byte k targets address {A[23:8], (A[7:0]+k) mod 256}.
- R5: Each array write follows a `mem_rd_en` cycle at the same address, with `mem_rdata` valid in the cycle after the read. The written value is the old value AND the buffered byte. Offsets are written in ascending order 0..255.
- R6: Data that passes offset 255 continues at offset 0 of the same page. It never reaches the next page.
- R7: When more than 256 data bytes are sent, each offset keeps the last byte received for it.
- R8: If chip select rises inside a byte, or before any data byte, the frame is discarded: there is no program cycle and no write, and `wel` is cleared.
- R9: An accepted frame holds `busy` high for exactly PROG_CYCLES clocks. `wel` is 0 once `busy` falls.
- R10: Frames sent while `busy` is high have no effect. Only the running program's writes occur.
- R11: A frame with any other opcode leaves `wel` and the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; SPI pins are oversampled by it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data in |
| busy | output | 1 | Program cycle in progress |
| wel | output | 1 | Write enable latch |
| mem_addr | output | 24 | Array byte address |
| mem_rd_en | output | 1 | Array read strobe |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid one clock after `mem_rd_en` |

## Verification
Several internal faults show up at the ports. A wrong buffer offset or a broken wrap shows up as a write to the wrong array address. A stale buffer valid bit shows up as an extra write. A latch that is not cleared shows up as a later program frame that is accepted when it should not be. Each of these appears either during the next program walk or as soon as the following frame's chip select rises. A program timer that is off by one changes the length of the `busy` window in that same program cycle.

// File: rtl/spi_pp_pkg.sv
package spi_pp_pkg;
  localparam logic [7:0] OP_ARM  = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;

  typedef enum logic [1:0] {ST_OPCODE, ST_ADDR, ST_DATA, ST_SKIP} frame_st_t;

  // programming only clears bits
  function automatic logic [7:0] clear_only(input logic [7:0] old_v, input logic [7:0] new_v);
    return old_v & new_v;
  endfunction

  // next offset inside a page, wrapping at the page end
  function automatic logic [7:0] wrap_next(input logic [7:0] off, input int unsigned aw);
    logic [7:0] mask;
    mask = 8'((1 << aw) - 1);
    return (off + 8'd1) & mask;
  endfunction
endpackage

// File: rtl/spi_pp_shifter.sv
module spi_pp_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       byte_vld,
  output logic [7:0] byte_val,
  output logic       cs_rise,
  output logic       on_boundary
);
  logic       s_sclk, s_cs, s_mosi, p_sclk, p_cs;
  logic [6:0] sh;
  logic [2:0] bcnt;
  logic       sclk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk <= 1'b0;
      s_cs   <= 1'b1;
      s_mosi <= 1'b0;
      p_sclk <= 1'b0;
      p_cs   <= 1'b1;
    end else begin
      s_sclk <= sclk;
      s_cs   <= cs_n;
      s_mosi <= mosi;
      p_sclk <= s_sclk;
      p_cs   <= s_cs;
    end
  end

  assign sclk_rise   = s_sclk & ~p_sclk & ~s_cs;
  assign cs_rise     = s_cs & ~p_cs;
  assign on_boundary = (bcnt == 3'd0);
  assign byte_vld    = sclk_rise && (bcnt == 3'd7);
  assign byte_val    = {sh, s_mosi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      bcnt <= '0;
    end else if (s_cs) begin
      bcnt <= '0;
    end else if (sclk_rise) begin
      sh   <= {sh[5:0], s_mosi};
      bcnt <= bcnt + 3'd1;
    end
  end
endmodule

// File: rtl/spi_pp_decoder.sv
module spi_pp_decoder #(
  parameter int ADDR_W  = 24,
  parameter int PAGE_AW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      byte_vld,
  input  logic [7:0]                byte_val,
  input  logic                      cs_rise,
  input  logic                      on_boundary,
  input  logic                      busy,
  input  logic                      prog_done,
  output logic                      wel,
  output logic                      launch,
  output logic                      discard,
  output logic                      buf_clear,
  output logic                      buf_we,
  output logic [PAGE_AW-1:0]        buf_idx,
  output logic [7:0]                buf_wdata,
  output logic [ADDR_W-PAGE_AW-1:0] page
);
  import spi_pp_pkg::*;

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int ACW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  frame_st_t          state;
  logic [ACW-1:0]     acnt;
  logic [ADDR_W-1:0]  addr;
  logic [PAGE_AW-1:0] off;
  logic               have_data;
  logic               arm_hit, prog_ok;
  logic [ADDR_W-1:0]  nxt_addr;

  assign arm_hit   = (state == ST_OPCODE) && byte_vld && !busy && (byte_val == OP_ARM);
  assign prog_ok   = (state == ST_OPCODE) && byte_vld && !busy && (byte_val == OP_PROG) && wel;
  assign buf_clear = prog_ok;
  assign buf_we    = (state == ST_DATA) && byte_vld;
  assign buf_idx   = off;
  assign buf_wdata = byte_val;
  assign launch    = cs_rise && (state == ST_DATA) && have_data && on_boundary;
  assign discard   = cs_rise && ((state == ST_ADDR) || ((state == ST_DATA) && !launch));
  assign page      = addr[ADDR_W-1:PAGE_AW];
  assign nxt_addr  = {addr[ADDR_W-9:0], byte_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel <= 1'b0;
    else if (prog_done || discard) wel <= 1'b0;
    else if (arm_hit) wel <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OPCODE;
      acnt      <= '0;
      addr      <= '0;
      off       <= '0;
      have_data <= 1'b0;
    end else if (cs_rise) begin
      state <= ST_OPCODE;
    end else if (byte_vld) begin
      unique case (state)
        ST_OPCODE: begin
          if (prog_ok) begin
            state     <= ST_ADDR;
            acnt      <= '0;
            have_data <= 1'b0;
          end else begin
            state <= ST_SKIP;
          end
        end
        ST_ADDR: begin
          addr <= nxt_addr;
          acnt <= acnt + 1'b1;
          if (acnt == ACW'(ADDR_BYTES - 1)) begin
            state <= ST_DATA;
            off   <= nxt_addr[PAGE_AW-1:0];
          end
        end
        ST_DATA: begin
          off       <= PAGE_AW'(wrap_next(8'(off), PAGE_AW));
          have_data <= 1'b1;
        end
        default: state <= ST_SKIP;
      endcase
    end
  end
endmodule

// File: rtl/spi_pp_pagebuf.sv
module spi_pp_pagebuf #(
  parameter int PAGE_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               we,
  input  logic [PAGE_AW-1:0] widx,
  input  logic [7:0]         wdata,
  input  logic [PAGE_AW-1:0] ridx,
  output logic [7:0]         rdata,
  output logic               rvalid
);
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  logic [7:0]            store [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) store[widx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (clear) vld <= '0;
    else if (we) vld[widx] <= 1'b1;
  end

  assign rdata  = store[ridx];
  assign rvalid = vld[ridx];
endmodule

// File: rtl/spi_pp_programmer.sv
module spi_pp_programmer #(
  parameter int ADDR_W      = 24,
  parameter int PAGE_AW     = 8,
  parameter int PROG_CYCLES = 600
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      launch,
  input  logic [ADDR_W-PAGE_AW-1:0] page_in,
  output logic                      busy,
  output logic                      prog_done,
  output logic [PAGE_AW-1:0]        ridx,
  input  logic [7:0]                bdata,
  input  logic                      bvalid,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_rd_en,
  output logic                      mem_wr_en,
  output logic [7:0]                mem_wdata,
  input  logic [7:0]                mem_rdata
);
  import spi_pp_pkg::*;

  localparam int WALK = 2 * (1 << PAGE_AW);
  localparam int TW   = $clog2(PROG_CYCLES + WALK) + 1;

  logic [TW-1:0]             tmr;
  logic [ADDR_W-PAGE_AW-1:0] page_q;
  logic                      walking, phase;

  assign walking   = busy && (tmr < TW'(WALK));
  assign phase     = tmr[0];
  assign ridx      = tmr[PAGE_AW:1];
  assign mem_rd_en = walking && !phase && bvalid;
  assign mem_wr_en = walking && phase && bvalid;
  assign mem_wdata = clear_only(mem_rdata, bdata);
  assign mem_addr  = {page_q, ridx};
  assign prog_done = busy && (tmr == TW'(PROG_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tmr    <= '0;
      page_q <= '0;
    end else if (launch && !busy) begin
      busy   <= 1'b1;
      tmr    <= '0;
      page_q <= page_in;
    end else if (prog_done) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (busy) begin
      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/spi_pp_engine.sv
module spi_pp_engine #(
  parameter int ADDR_W      = 24,
  parameter int PAGE_AW     = 8,
  parameter int PROG_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              busy,
  output logic              wel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic                      byte_vld, cs_rise, on_boundary;
  logic [7:0]                byte_val;
  logic                      launch_w, discard_w, prog_done_w;
  logic                      buf_clear, buf_we, bvalid;
  logic [PAGE_AW-1:0]        buf_idx, ridx;
  logic [7:0]                buf_wdata, bdata;
  logic [ADDR_W-PAGE_AW-1:0] page;

  spi_pp_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .byte_vld(byte_vld), .byte_val(byte_val), .cs_rise(cs_rise), .on_boundary(on_boundary)
  );

  spi_pp_decoder #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW)) dec_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_val(byte_val),
    .cs_rise(cs_rise), .on_boundary(on_boundary), .busy(busy), .prog_done(prog_done_w),
    .wel(wel), .launch(launch_w), .discard(discard_w), .buf_clear(buf_clear),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata), .page(page)
  );

  spi_pp_pagebuf #(.PAGE_AW(PAGE_AW)) buf_i (
    .clk(clk), .rst_n(rst_n), .clear(buf_clear), .we(buf_we), .widx(buf_idx),
    .wdata(buf_wdata), .ridx(ridx), .rdata(bdata), .rvalid(bvalid)
  );

  spi_pp_programmer #(.ADDR_W(ADDR_W), .PAGE_AW(PAGE_AW), .PROG_CYCLES(PROG_CYCLES)) prog_i (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .page_in(page), .busy(busy),
    .prog_done(prog_done_w), .ridx(ridx), .bdata(bdata), .bvalid(bvalid),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/spi_pp_engine_chk.sv
module spi_pp_engine_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              wel,
  input logic              launch,
  input logic              discard,
  input logic              prog_done,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic [7:0]        mem_rdata
);
  assert_launch_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> wel);
  assert_busy_after_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  assert_wel_drop_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (!wel && !busy));
  assert_strobe_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> busy);
  assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ((mem_wdata & ~mem_rdata) == 8'h00));
  assert_rmw_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && (mem_addr == $past(mem_addr))));
  assert_discard_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (!wel && !busy));
  assert_no_launch_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);
endmodule

bind spi_pp_engine spi_pp_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .launch(launch_w),
  .discard(discard_w), .prog_done(prog_done_w), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata)
);

// File: tb/spi_pp_engine_tb.sv
`timescale 1ns/1ps
module spi_pp_engine_tb_top;
  localparam int PROG_CYCLES = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic busy, wel, mem_rd_en, mem_wr_en;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  spi_pp_engine #(.PROG_CYCLES(PROG_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .busy(busy), .wel(wel), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // array model
  logic [7:0] arr [int];
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= arr.exists(int'(mem_addr)) ? arr[int'(mem_addr)] : 8'hFF;
    if (mem_wr_en) arr[int'(mem_addr)] = mem_wdata;
  end

  // expected mirror and scoreboard
  logic [7:0] emem [int];
  typedef struct { logic [23:0] a; logic [7:0] d; } wr_t;
  wr_t sb_q[$];
  logic [7:0] tx_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected writes
  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected array write", {mem_addr, mem_wdata}, 32'h0);
      end else begin
        wr_t e;
        e = sb_q.pop_front();
        chk(mem_addr == e.a && mem_wdata == e.d, "R5", "array write",
            {mem_addr, mem_wdata}, {e.a, e.d});
      end
    end
  end

  // busy window measurement
  int busy_run = 0, last_len = 0, n_prog = 0;
  always @(negedge clk) begin
    if (busy) busy_run++;
    else if (busy_run != 0) begin
      last_len = busy_run;
      busy_run = 0;
      n_prog++;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  task automatic spi_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk) spi_mosi = b[i];
      repeat (3) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (3) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic cs_low();  @(negedge clk) spi_cs_n = 1'b0; repeat (2) @(negedge clk); endtask
  task automatic cs_high(); repeat (2) @(negedge clk); spi_cs_n = 1'b1; repeat (6) @(negedge clk); endtask

  task automatic send_arm();
    cs_low(); spi_bits(8'h06, 8); cs_high();
  endtask

  // opcode, optional address, data bytes from tx_q, optional trailing partial bits
  task automatic send_frame(input logic [7:0] op, input logic [23:0] a, input bit with_addr,
                            input int tail_bits);
    cs_low();
    spi_bits(op, 8);
    if (with_addr) begin
      spi_bits(a[23:16], 8); spi_bits(a[15:8], 8); spi_bits(a[7:0], 8);
    end
    foreach (tx_q[i]) spi_bits(tx_q[i], 8);
    if (tail_bits > 0) spi_bits(8'hA5, tail_bits);
    cs_high();
  endtask

  function automatic logic [7:0] get_e(input logic [23:0] a);
    return emem.exists(int'(a)) ? emem[int'(a)] : 8'hFF;
  endfunction

  // independent page model: wrap, last-writer-wins, ascending walk, AND merge
  task automatic expect_program(input logic [23:0] a);
    logic [7:0] pb [256];
    bit         pv [256];
    for (int o = 0; o < 256; o++) pv[o] = 0;
    for (int k = 0; k < tx_q.size(); k++) begin
      int o;
      o = (int'(a[7:0]) + k) % 256;
      pb[o] = tx_q[k];
      pv[o] = 1;
    end
    for (int o = 0; o < 256; o++) begin
      if (pv[o]) begin
        wr_t w;
        w.a = {a[23:8], 8'(o)};
        w.d = get_e(w.a) & pb[o];
        emem[int'(w.a)] = w.d;
        sb_q.push_back(w);
      end
    end
  endtask

  task automatic wait_prog(input int np, input string req);
    int guard = 0;
    while (n_prog == np && guard < 5000) begin @(negedge clk); guard++; end
    chk(n_prog == np + 1, req, "program cycle completed", n_prog, np + 1);
    chk(last_len == PROG_CYCLES, "R9", "busy window length", last_len, PROG_CYCLES);
    chk(wel == 1'b0, "R9", "wel after program", wel, 0);
    chk(sb_q.size() == 0, req, "all expected writes seen", sb_q.size(), 0);
  endtask

  task automatic expect_quiet(input int np, input string req, input logic exp_wel);
    repeat (60) @(negedge clk);
    chk(n_prog == np, req, "no program cycle", n_prog, np);
    chk(busy == 1'b0, req, "busy stays low", busy, 0);
    chk(wel == exp_wel, req, "wel state", wel, exp_wel);
  endtask

  initial begin
    int np;
    repeat (3) @(negedge clk);
    chk(busy == 0 && wel == 0 && mem_rd_en == 0 && mem_wr_en == 0, "R1", "reset outputs",
        {busy, wel, mem_rd_en, mem_wr_en}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 0 && wel == 0, "R1", "idle after reset release", {busy, wel}, 0);

    // R3: program without arming
    np = n_prog;
    tx_q = '{8'hAA};
    send_frame(8'h02, 24'h001000, 1, 0);
    expect_quiet(np, "R3", 1'b0);

    // R2 / R4 / R5: basic program
    send_arm();
    chk(wel == 1'b1, "R2", "wel after arm", wel, 1);
    np = n_prog;
    tx_q = '{8'h5A, 8'h0F, 8'hF0};
    expect_program(24'h012340);
    send_frame(8'h02, 24'h012340, 1, 0);
    wait_prog(np, "R4");

    // R5: AND with existing content
    send_arm();
    np = n_prog;
    tx_q = '{8'h33};
    expect_program(24'h012341);
    send_frame(8'h02, 24'h012341, 1, 0);
    wait_prog(np, "R5");

    // R6: wrap inside the page
    send_arm();
    np = n_prog;
    tx_q = '{8'h11, 8'h22, 8'h33, 8'h44};
    expect_program(24'h0200FE);
    send_frame(8'h02, 24'h0200FE, 1, 0);
    wait_prog(np, "R6");

    // R7: more than a page of data
    send_arm();
    np = n_prog;
    tx_q.delete();
    for (int i = 0; i < 258; i++) tx_q.push_back(8'(i * 7 + 3));
    expect_program(24'h030000);
    send_frame(8'h02, 24'h030000, 1, 0);
    wait_prog(np, "R7");

    // R8: chip select rises inside a byte
    send_arm();
    np = n_prog;
    tx_q = '{8'h00};
    send_frame(8'h02, 24'h030000, 1, 3);
    expect_quiet(np, "R8", 1'b0);

    // R8: no data byte at all
    send_arm();
    np = n_prog;
    tx_q.delete();
    send_frame(8'h02, 24'h030000, 1, 0);
    expect_quiet(np, "R8", 1'b0);

    // R11: unknown opcode leaves wel and array alone
    send_arm();
    np = n_prog;
    tx_q = '{8'h00, 8'h00};
    send_frame(8'h03, 24'h012340, 1, 0);
    expect_quiet(np, "R11", 1'b1);

    // R10: frames during busy are ignored (wel is still set from above)
    np = n_prog;
    tx_q = '{8'h81};
    expect_program(24'h040010);
    send_frame(8'h02, 24'h040010, 1, 0);
    chk(busy == 1'b1, "R10", "busy during reject test", busy, 1);
    tx_q = '{8'h00};
    send_frame(8'h02, 24'h050000, 1, 0);
    send_arm();
    wait_prog(np, "R10");
    np = n_prog;
    repeat (20) @(negedge clk);
    chk(n_prog == np && busy == 0, "R10", "no second program", n_prog, np);

    // R3 again: latch really dropped after the cycle
    tx_q = '{8'h00};
    send_frame(8'h02, 24'h050000, 1, 0);
    expect_quiet(np, "R3", 1'b0);
    chk(sb_q.size() == 0, "R10", "scoreboard empty at end", sb_q.size(), 0);

    finished = 1;
    summary();
  end
endmodule